// File: doc/BRIEF.md
# System Tick Down-Counter Timer

This block is a periodic down-counter that raises a regular tick interrupt for a processor. Software sets it up through four 32-bit word registers: a control/status word, a reload value, the live count and a constant calibration word. Once running, the counter starts from the reload value and steps down by one on each count tick. A count tick is either every core clock cycle or each pulse of an external reference strobe, chosen by a bit in the control word. The tick after the count reaches zero is an expiry. On expiry the block sets a sticky wrap flag, optionally pulses the interrupt line for one cycle, and either reloads or stops.

The register port takes one request per cycle, with a write strobe, a byte address, write data and an unprivileged attribute. Every request gets a response exactly one cycle later: read data, or an error for an unprivileged access. Side effects are part of the register contract. Reading the control word clears the wrap flag. Any write to the live-count register restarts the period.

Top module: `tick_timer`

## Requirements
- R1: After reset the control word, the reload value and the live count all read 0, and `irq_pulse` and `rsp_valid` are low.
- R2: A write to offset 0x0 updates only control bits [2:0] (bit 0 run, bit 1 interrupt enable, bit 2 clock select, 1 = every core cycle, 0 = reference strobe). A read of offset 0x0 returns those bits with the wrap flag in bit 16 and zero elsewhere.
- R3: When the run bit goes from 0 to 1, the live count loads the reload value (offset 0x4) and then drops by one per count tick. A tick at count zero is an expiry: it sets the wrap flag and reloads, so one period spans reload+1 ticks.
- R4: With clock select 0, the count changes only in cycles where `ref_tick` is high. With clock select 1, it changes every cycle.
- R5: `irq_pulse` is high for exactly one cycle, in the cycle after an expiry, and only if the interrupt-enable bit was set.
- R6: A read of offset 0x0 returns the wrap flag and then clears it, unless an expiry happens in the same cycle; in that case the flag stays set.
- R7: An expiry while the reload value is zero clears the run bit, and counting stops.
- R8: A write of any data to offset 0x8 reloads the live count from the reload value and clears the wrap flag. No count tick is applied in that cycle.
- R9: A read of offset 0x8 returns the live count while running and 0 while the run bit is clear.
- R10: Offset 0xC reads the constant 10000. Any other offset, including one that is not word aligned, reads 0 and ignores writes.
- R11: A request with `req_unpriv` high returns `rsp_err` high with read data 0 and changes no register.
- R12: A control write that keeps the run bit unchanged but flips clock select reloads the live count from the reload value.
- R13: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. `rsp_rdata` is 0 except for an accepted read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | Reference count strobe, one cycle per tick |
| req_valid | input | 1 | Register request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| req_unpriv | input | 1 | Access is unprivileged |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Response is an access error |
| rsp_rdata | output | 32 | Read data |
| irq_pulse | output | 1 | One-cycle tick interrupt |

## Verification
The assertions assume that `ref_tick` is a clean single-cycle strobe. They also assume that each request is complete in the cycle `req_valid` is high, so that control, live-count and reload writes are never split across cycles. The stimulus drives every input once per cycle on the falling edge. Reload values stay small so that expiries, zero-reload stops and reloads happen often. Unprivileged, misaligned and unmapped accesses are mixed in at random alongside directed sequences, and these include read-clear of the wrap flag and clock-select switches.

// File: rtl/tick_pkg.sv
package tick_pkg;
  localparam int OFS_CTRL    = 0;
  localparam int OFS_RELOAD  = 4;
  localparam int OFS_CURRENT = 8;
  localparam int OFS_CALIB   = 12;

  localparam int BIT_RUN   = 0;
  localparam int BIT_IRQEN = 1;
  localparam int BIT_CLKSEL = 2;
  localparam int BIT_WRAP  = 16;

  typedef struct packed {
    logic wr_ctrl;
    logic wr_rel;
    logic wr_cur;
    logic rd_ctrl;
    logic rd_rel;
    logic rd_cur;
    logic rd_cal;
    logic denied;
  } acc_t;
endpackage

// File: rtl/tick_decode.sv
module tick_decode
  import tick_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_unpriv,
  output acc_t              acc
);
  logic ok, is_ctrl, is_rel, is_cur, is_cal;

  always_comb begin
    ok      = req_valid && !req_unpriv;
    is_ctrl = (req_addr == ADDR_W'(OFS_CTRL));
    is_rel  = (req_addr == ADDR_W'(OFS_RELOAD));
    is_cur  = (req_addr == ADDR_W'(OFS_CURRENT));
    is_cal  = (req_addr == ADDR_W'(OFS_CALIB));
    acc.wr_ctrl = ok && req_write && is_ctrl;
    acc.wr_rel  = ok && req_write && is_rel;
    acc.wr_cur  = ok && req_write && is_cur;
    acc.rd_ctrl = ok && !req_write && is_ctrl;
    acc.rd_rel  = ok && !req_write && is_rel;
    acc.rd_cur  = ok && !req_write && is_cur;
    acc.rd_cal  = ok && !req_write && is_cal;
    acc.denied  = req_valid && req_unpriv;
  end
endmodule

// File: rtl/tick_core.sv
module tick_core
  import tick_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_tick,
  input  logic             wr_ctrl,
  input  logic             wr_rel,
  input  logic             wr_cur,
  input  logic             rd_ctrl,
  input  logic [31:0]      wdata,
  output logic [31:0]      ctrl_word,
  output logic [CNT_W-1:0] reload_q,
  output logic [CNT_W-1:0] count_q,
  output logic             running,
  output logic             irq_q
);
  logic run_q, irqen_q, clksel_q, wrap_q;
  logic step, expire, reload_now;

  generate
    if (CNT_W < 32) begin : g_spare
      logic unused_spare;
      assign unused_spare = ^wdata[31:CNT_W];
    end
  endgenerate

  always_comb begin
    step   = run_q && (clksel_q || ref_tick);
    expire = step && (count_q == '0) && !wr_ctrl && !wr_cur;
    reload_now = wr_ctrl &&
                 ((wdata[BIT_RUN] && !run_q) ||
                  ((wdata[BIT_RUN] == run_q) && (wdata[BIT_CLKSEL] != clksel_q)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      irqen_q  <= 1'b0;
      clksel_q <= 1'b0;
      wrap_q   <= 1'b0;
      reload_q <= '0;
      count_q  <= '0;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= expire && irqen_q;
      if (wr_rel) reload_q <= wdata[CNT_W-1:0];

      if (wr_ctrl) begin
        run_q    <= wdata[BIT_RUN];
        irqen_q  <= wdata[BIT_IRQEN];
        clksel_q <= wdata[BIT_CLKSEL];
      end else if (expire && reload_q == '0) begin
        run_q <= 1'b0;
      end

      if (reload_now || wr_cur) begin
        count_q <= reload_q;
      end else if (!wr_ctrl && step) begin
        if (count_q == '0) count_q <= reload_q;
        else               count_q <= count_q - 1'b1;
      end

      if (expire)                wrap_q <= 1'b1;
      else if (rd_ctrl || wr_cur) wrap_q <= 1'b0;
    end
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[BIT_RUN]    = run_q;
    ctrl_word[BIT_IRQEN]  = irqen_q;
    ctrl_word[BIT_CLKSEL] = clksel_q;
    ctrl_word[BIT_WRAP]   = wrap_q;
    running = run_q;
  end

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst) irq_q |=> !irq_q); // R5
  AST_IRQ_WITH_WRAP: assert property (@(posedge clk) disable iff (rst) irq_q |-> wrap_q); // R5
  AST_ZERO_RELOAD_HALT: assert property (@(posedge clk) disable iff (rst)
    (expire && reload_q == '0) |=> !run_q); // R7
  AST_EXPIRE_RELOADS: assert property (@(posedge clk) disable iff (rst)
    (expire && reload_q != '0) |=> (count_q == $past(reload_q)) && wrap_q); // R3
  AST_CUR_WRITE_RELOADS: assert property (@(posedge clk) disable iff (rst)
    wr_cur |=> (count_q == $past(reload_q)) && !wrap_q); // R8
  AST_REF_GATED: assert property (@(posedge clk) disable iff (rst)
    (!clksel_q && !ref_tick && !wr_ctrl && !wr_cur) |=> $stable(count_q)); // R4
endmodule

// File: rtl/tick_rdmux.sv
module tick_rdmux
  import tick_pkg::*;
#(
  parameter int CNT_W     = 24,
  parameter int CAL_VALUE = 10000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  acc_t             acc,
  input  logic [31:0]      ctrl_word,
  input  logic [CNT_W-1:0] reload_q,
  input  logic [CNT_W-1:0] count_q,
  input  logic             running,
  output logic             rsp_valid,
  output logic             rsp_err,
  output logic [31:0]      rsp_rdata
);
  logic [31:0] rdata_n;
  logic unused_wr;

  assign unused_wr = acc.wr_ctrl ^ acc.wr_rel ^ acc.wr_cur;

  always_comb begin
    rdata_n = '0;
    if (acc.rd_ctrl)     rdata_n = ctrl_word;
    else if (acc.rd_rel) rdata_n = 32'(reload_q);
    else if (acc.rd_cur) rdata_n = running ? 32'(count_q) : '0;
    else if (acc.rd_cal) rdata_n = 32'(CAL_VALUE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= acc.denied;
      rsp_rdata <= rdata_n;
    end
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int CNT_W     = 24,
  parameter int CAL_VALUE = 10000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_tick,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic              req_unpriv,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [31:0]       rsp_rdata,
  output logic              irq_pulse
);
  acc_t             acc;
  logic [31:0]      ctrl_word;
  logic [CNT_W-1:0] reload_q, count_q;
  logic             running;

  tick_decode #(.ADDR_W(ADDR_W)) u_decode (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_unpriv(req_unpriv),
    .acc       (acc)
  );

  tick_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst      (rst),
    .ref_tick (ref_tick),
    .wr_ctrl  (acc.wr_ctrl),
    .wr_rel   (acc.wr_rel),
    .wr_cur   (acc.wr_cur),
    .rd_ctrl  (acc.rd_ctrl),
    .wdata    (req_wdata),
    .ctrl_word(ctrl_word),
    .reload_q (reload_q),
    .count_q  (count_q),
    .running  (running),
    .irq_q    (irq_pulse)
  );

  tick_rdmux #(.CNT_W(CNT_W), .CAL_VALUE(CAL_VALUE)) u_rdmux (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .acc      (acc),
    .ctrl_word(ctrl_word),
    .reload_q (reload_q),
    .count_q  (count_q),
    .running  (running),
    .rsp_valid(rsp_valid),
    .rsp_err  (rsp_err),
    .rsp_rdata(rsp_rdata)
  );

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R13
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid); // R13
  AST_DENIED_ERR: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_unpriv) |=> rsp_err && (rsp_rdata == '0)); // R11
  AST_DENIED_KEEPS_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_unpriv) |=> $stable(reload_q)); // R11
endmodule

// File: tb/tick_timer_bench.sv
module tick_timer_bench;
  localparam int CW = 24;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ref_tick = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_unpriv = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_err, irq_pulse;
  logic [31:0] rsp_rdata;

  always #2.5 clk = ~clk;

  tick_timer u_tick_timer (
    .clk(clk), .rst(rst), .ref_tick(ref_tick),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_unpriv(req_unpriv),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .irq_pulse(irq_pulse)
  );

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  // reference model state
  bit          m_run, m_ie, m_cs, m_wrap;
  logic [CW-1:0] m_rel, m_cur;
  bit          e_valid, e_err, e_irq;
  logic [31:0] e_rdata;
  string       e_tag;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [31:0] ctrl_img();
    return {15'd0, m_wrap, 13'd0, m_cs, m_ie, m_run};
  endfunction

  // one clock of stimulus: model prediction, edge, comparison
  task automatic step(input bit v, input bit w, input logic [7:0] a, input logic [31:0] d,
                      input bit u, input bit rt, input string tag);
    bit ok, wr, rd, supp, tk, exp_now, ld;
    req_valid = v; req_write = w; req_addr = a; req_wdata = d; req_unpriv = u; ref_tick = rt;
    ok = v && !u; wr = ok && w; rd = ok && !w;
    e_valid = v; e_err = v && u; e_rdata = '0;
    if (rd) begin
      case (a)
        8'h00: begin e_rdata = ctrl_img(); e_tag = (tag != "") ? tag : "R6"; end
        8'h04: begin e_rdata = 32'(m_rel); e_tag = (tag != "") ? tag : "R3"; end
        8'h08: begin e_rdata = m_run ? 32'(m_cur) : 0; e_tag = (tag != "") ? tag : (m_run ? "R3" : "R9"); end
        8'h0C: begin e_rdata = 32'd10000; e_tag = (tag != "") ? tag : "R10"; end
        default: begin e_rdata = 0; e_tag = (tag != "") ? tag : "R10"; end
      endcase
    end else begin
      e_tag = (tag != "") ? tag : (u ? "R11" : "R13");
    end
    supp = wr && (a == 8'h00 || a == 8'h08);
    tk = m_run && (m_cs || rt);
    exp_now = tk && (m_cur == 0) && !supp;
    e_irq = exp_now && m_ie;
    if (wr && a == 8'h00) begin
      ld = (d[0] && !m_run) || ((d[0] == m_run) && (d[2] != m_cs));
      if (ld) m_cur = m_rel;
      m_run = d[0]; m_ie = d[1]; m_cs = d[2];
    end else if (wr && a == 8'h08) begin
      m_cur = m_rel; m_wrap = 0;
    end else if (tk) begin
      if (m_cur == 0) begin
        m_wrap = 1;
        if (m_rel == 0) m_run = 0; else m_cur = m_rel;
      end else m_cur = m_cur - 1'b1;
    end
    if (rd && a == 8'h00 && !exp_now) m_wrap = 0;
    if (wr && a == 8'h04) m_rel = d[CW-1:0];
    @(posedge clk);
    @(negedge clk);
    chk(32'(rsp_valid), 32'(e_valid), "R13");
    chk(32'(irq_pulse), 32'(e_irq), "R5");
    if (e_valid) begin
      chk(32'(rsp_err), 32'(e_err), "R11");
      chk(rsp_rdata, e_rdata, e_tag);
    end
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    step(1, 0, a, 0, 0, 0, tag);
  endtask
  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
    step(1, 1, a, d, 0, 0, tag);
  endtask
  task automatic idle(input int n, input bit rt);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, rt, "");
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int irq_count;
    void'($urandom(32'd2718));
    m_run = 0; m_ie = 0; m_cs = 0; m_wrap = 0; m_rel = '0; m_cur = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(32'(rsp_valid), 0, "R1");
    chk(32'(irq_pulse), 0, "R1");
    rd(8'h00, "R1"); rd(8'h04, "R1"); rd(8'h08, "R1");
    // R2: only low three control bits are writable
    wr(8'h00, 32'hFFFF_FFFA, "R2");
    rd(8'h00, "R2");
    wr(8'h00, 32'h0, "R2");
    // R10: calibration and unmapped
    rd(8'h0C, "R10"); rd(8'h10, "R10"); rd(8'h05, "R10");
    wr(8'h14, 32'h55, "R10"); wr(8'h06, 32'h77, "R10");
    rd(8'h04, "R10");
    // R3/R5: period of reload+1 core cycles with interrupts
    wr(8'h04, 32'd3, "R3");
    wr(8'h00, 32'd7, "R3");
    irq_count = 0;
    for (int i = 0; i < 12; i++) begin
      step(0, 0, 0, 0, 0, 0, "");
      if (irq_pulse) irq_count++;
    end
    chk(32'(irq_count), 32'd3, "R3");
    rd(8'h00, "R6"); rd(8'h00, "R6");
    // R12: clock select flip keeps run, reloads
    idle(2, 0);
    wr(8'h00, 32'd3, "R12");
    rd(8'h08, "R12");
    // R4: reference strobe gating
    idle(3, 0);
    rd(8'h08, "R4");
    idle(2, 1);
    rd(8'h08, "R4");
    // R8: write to current reloads and clears flag
    wr(8'h00, 32'd5, "R8");
    idle(5, 0);
    wr(8'h08, 32'hDEAD, "R8");
    rd(8'h08, "R8"); rd(8'h00, "R8");
    // R7: zero reload stops after one expiry
    wr(8'h04, 32'd0, "R7");
    wr(8'h00, 32'd0, "R7");
    wr(8'h00, 32'd7, "R7");
    idle(3, 0);
    rd(8'h00, "R7");
    rd(8'h08, "R9");
    // R11: denied accesses
    step(1, 1, 8'h04, 32'd9, 1, 0, "R11");
    step(1, 0, 8'h0C, 0, 1, 0, "R11");
    rd(8'h04, "R11");
    // random mix
    for (int i = 0; i < 5000; i++) begin
      int k;
      bit u, rt;
      logic [7:0] a;
      logic [7:0] addrs [8] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h01, 8'h20, 8'hFC};
      k = $urandom % 12;
      u = ($urandom % 8) == 0;
      rt = $urandom % 2;
      a = addrs[$urandom % 8];
      case (k)
        0, 1, 2: step(1, 0, a, 0, u, rt, "");
        3:       step(1, 1, 8'h00, {$urandom} | (($urandom % 4 != 0) ? 32'd1 : 32'd0), u, rt, "");
        4:       step(1, 1, 8'h04, $urandom % 6, u, rt, "");
        5:       step(1, 1, 8'h08, $urandom, u, rt, "");
        6:       step(1, 1, a, $urandom, u, rt, "");
        default: step(0, 0, 0, 0, 0, rt, "");
      endcase
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule